// File: doc/BRIEF.md
# Data Access Breakpoint Comparator

This block sits beside a CPU's data port and watches each load and store. When an access satisfies a condition that software has programmed, it emits a one-cycle breakpoint pulse toward the CPU's debug exception logic. Software programs the condition through a small memory-mapped register set. The set holds a control word, an inclusive lower and upper address bound, a compare value and a compare mask.

The condition has three parts. The first is an address test: the address is inside or outside the bounds. The second is a data test: the masked data equals or differs from the masked compare value. The third selects which kind of access is examined: loads, stores or both. A two-bit check mode enables the address test, the data test, both together, or nothing. The address test applies to every address, with no regard to memory region.

Top module: `dbrk_watch`

## Requirements
- R1: A synchronous reset clears the control word to zero, so no breakpoint can fire. The bound, value and mask registers keep no defined reset value.
- R2: The control word layout is: bits [1:0] check mode, bit 2 enables loads, bit 3 enables stores, bit 4 inverts the address test, bit 5 inverts the data test. Bits 31:6 read as zero whatever was written.
- R3: Check mode 0 produces no breakpoint for any access.
- R4: A load (`acc_store`=0) is examined only when bit 2 is set. A store (`acc_store`=1) is examined only when bit 3 is set.
- R5: In check mode 1 with bit 4 clear, an access matches when lower ≤ address ≤ upper, and both bounds match.
- R6: In check mode 1 with bit 4 set, an access matches when address < lower or address > upper.
- R7: In check mode 2 with bit 5 clear, an access matches when (data & mask) == (value & mask). Bits where the mask is 0 are ignored.
- R8: In check mode 2 with bit 5 set, an access matches when the masked data and the masked value differ.
- R9: In check mode 3, an access matches only when the address test and the data test both succeed on that same access.
- R10: `brk_pulse` is high for exactly the clock after an edge that sampled `acc_valid` high with a matching access. With `acc_valid` low, no breakpoint results.
- R11: The registers sit at BASE_ADDR plus these offsets: control 0x101020, lower bound 0x101030, upper bound 0x101034, compare value 0x101038, compare mask 0x10103C. Each is readable and writable. Read data appears on `cfg_rdata` one clock after `cfg_rd`.
- R12: A write to any other address changes no register. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Registered read data |
| acc_valid | input | 1 | A data access is present this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Access address |
| acc_data | input | DATA_W | Access data |
| brk_pulse | output | 1 | Registered breakpoint pulse |

## Verification
The hardest case is mode 3 when only one of the two tests succeeds. The bench exercises it by holding the address and data settings fixed and issuing three accesses: one that passes both tests, one that passes only the address test, and one that passes only the data test. The exact bound addresses and the addresses one past them are also hard to hit by chance, so the bench uses them directly. Each is tried under both polarities. The bounds, value and mask stay unknown after reset, so the bench enables a check mode only after it has programmed and read back all four.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

  typedef enum logic [1:0] {
    CHK_OFF  = 2'd0,
    CHK_ADDR = 2'd1,
    CHK_DATA = 2'd2,
    CHK_BOTH = 2'd3
  } chk_mode_e;

  // packed MSB first: data_inv is bit 5, mode occupies bits 1:0
  typedef struct packed {
    logic      data_inv;
    logic      addr_inv;
    logic      st_en;
    logic      ld_en;
    chk_mode_e mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int NREG   = 5;

  localparam logic [31:0] OFS_CTRL = 32'h0010_1020;
  localparam logic [31:0] OFS_LO   = 32'h0010_1030;
  localparam logic [31:0] OFS_HI   = 32'h0010_1034;
  localparam logic [31:0] OFS_VAL  = 32'h0010_1038;
  localparam logic [31:0] OFS_MSK  = 32'h0010_103C;

endpackage

// File: rtl/dbrk_regs.sv
module dbrk_regs
  import dbrk_pkg::*;
#(
  parameter int          CFG_AW    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q,
  output logic [DATA_W-1:0] val_q,
  output logic [DATA_W-1:0] msk_q
);

  localparam int IX_CTRL = 0;
  localparam int IX_LO   = 1;
  localparam int IX_HI   = 2;
  localparam int IX_VAL  = 3;
  localparam int IX_MSK  = 4;

  localparam logic [NREG-1:0][31:0] REG_OFS = {OFS_MSK, OFS_VAL, OFS_HI, OFS_LO, OFS_CTRL};

  logic [NREG-1:0]   sel;
  logic [DATA_W-1:0] word [NREG];
  logic [DATA_W-1:0] rd_mux;

  // one address comparator per register
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [31:0] FULL = BASE_ADDR + REG_OFS[i];
    assign sel[i] = (cfg_addr == FULL[CFG_AW-1:0]);
  end

  // control word is the only register with a defined reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (cfg_wr && sel[IX_CTRL]) begin
      ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end

  // condition registers: no reset, plain enables
  always_ff @(posedge clk) begin
    if (cfg_wr && sel[IX_LO])  lo_q  <= cfg_wdata[ADDR_W-1:0];
    if (cfg_wr && sel[IX_HI])  hi_q  <= cfg_wdata[ADDR_W-1:0];
    if (cfg_wr && sel[IX_VAL]) val_q <= cfg_wdata;
    if (cfg_wr && sel[IX_MSK]) msk_q <= cfg_wdata;
  end

  always_comb begin
    word[IX_CTRL]                = '0;
    word[IX_CTRL][CTRL_W-1:0]    = ctrl_q;
    word[IX_LO]                  = '0;
    word[IX_LO][ADDR_W-1:0]      = lo_q;
    word[IX_HI]                  = '0;
    word[IX_HI][ADDR_W-1:0]      = hi_q;
    word[IX_VAL]                 = val_q;
    word[IX_MSK]                 = msk_q;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) rd_mux = rd_mux | word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      cfg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/dbrk_match.sv
module dbrk_match
  import dbrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] msk,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              hit
);

  logic in_rng, addr_ok;
  logic data_eq, data_ok;
  logic kind_ok;

  assign in_rng  = (acc_addr >= lo) && (acc_addr <= hi);
  assign addr_ok = in_rng ^ ctrl.addr_inv;

  assign data_eq = (((acc_data ^ val) & msk) == '0);
  assign data_ok = data_eq ^ ctrl.data_inv;

  assign kind_ok = acc_store ? ctrl.st_en : ctrl.ld_en;

  always_comb begin
    hit = 1'b0;
    if (acc_valid && kind_ok) begin
      unique case (ctrl.mode)
        CHK_OFF:  hit = 1'b0;
        CHK_ADDR: hit = addr_ok;
        CHK_DATA: hit = data_ok;
        CHK_BOTH: hit = addr_ok && data_ok;
        default:  hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/dbrk_watch.sv
module dbrk_watch
  import dbrk_pkg::*;
#(
  parameter int          CFG_AW    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              brk_pulse
);

  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] val_q, msk_q;
  logic              hit;

  dbrk_regs #(
    .CFG_AW(CFG_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctrl_q(ctrl_q), .lo_q(lo_q), .hi_q(hi_q), .val_q(val_q), .msk_q(msk_q)
  );

  dbrk_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_match (
    .ctrl(ctrl_q), .lo(lo_q), .hi(hi_q), .val(val_q), .msk(msk_q),
    .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_addr(acc_addr), .acc_data(acc_data),
    .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) brk_pulse <= 1'b0;
    else     brk_pulse <= hit;
  end

endmodule

// File: rtl/dbrk_watch_chk.sv
module dbrk_watch_chk
  import dbrk_pkg::*;
#(
  parameter int          CFG_AW    = 32,
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rd,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              acc_valid,
  input logic              acc_store,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              brk_pulse,
  input ctrl_t             ctrl_q,
  input logic [ADDR_W-1:0] lo_q,
  input logic [ADDR_W-1:0] hi_q
);

  localparam logic [31:0] CTRL_FULL = BASE_ADDR + OFS_CTRL;

  p_ctrl_clear_r1: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0));

  p_ctrl_pad_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == CTRL_FULL[CFG_AW-1:0]) |=> (cfg_rdata[DATA_W-1:CTRL_W] == '0));

  p_mode_off_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.mode == CHK_OFF) |=> !brk_pulse);

  p_load_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_store && !ctrl_q.ld_en) |=> !brk_pulse);

  p_store_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_store && !ctrl_q.st_en) |=> !brk_pulse);

  p_inside_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_store && ctrl_q.ld_en && ctrl_q.mode == CHK_ADDR && !ctrl_q.addr_inv
     && acc_addr >= lo_q && acc_addr <= hi_q) |=> brk_pulse);

  p_outside_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_store && ctrl_q.ld_en && ctrl_q.mode == CHK_ADDR && ctrl_q.addr_inv
     && acc_addr >= lo_q && acc_addr <= hi_q) |=> !brk_pulse);

  p_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !brk_pulse);

endmodule

bind dbrk_watch dbrk_watch_chk #(
  .CFG_AW(CFG_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
  .brk_pulse(brk_pulse), .ctrl_q(ctrl_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/dbrk_watch_tb.sv
module dbrk_watch_tb;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] A_CTRL = BASE + 32'h0010_1020;
  localparam logic [31:0] A_LO   = BASE + 32'h0010_1030;
  localparam logic [31:0] A_HI   = BASE + 32'h0010_1034;
  localparam logic [31:0] A_VAL  = BASE + 32'h0010_1038;
  localparam logic [31:0] A_MSK  = BASE + 32'h0010_103C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [31:0] cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic        acc_valid = 1'b0, acc_store = 1'b0;
  logic [31:0] acc_addr = '0, acc_data = '0;
  logic        brk_pulse;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  dbrk_watch #(.BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_store(acc_store), .acc_addr(acc_addr), .acc_data(acc_data),
    .brk_pulse(brk_pulse)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference: model registers and expected pulse
  logic [31:0] m_ctrl, m_lo, m_hi, m_val, m_msk;
  bit          exp_q;

  function automatic bit model_hit();
    bit a_ok, d_ok;
    int mode;
    if (!acc_valid) return 1'b0;
    if (acc_store ? !m_ctrl[3] : !m_ctrl[2]) return 1'b0;
    mode = int'(m_ctrl[1:0]);
    if (mode == 0) return 1'b0;
    a_ok = ((acc_addr >= m_lo) && (acc_addr <= m_hi)) != m_ctrl[4];
    d_ok = ((acc_data & m_msk) == (m_val & m_msk)) != m_ctrl[5];
    if (mode == 1) return a_ok;
    if (mode == 2) return d_ok;
    return a_ok && d_ok;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl <= '0;
      exp_q  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        if (cfg_addr == A_CTRL) m_ctrl <= {26'b0, cfg_wdata[5:0]};
        if (cfg_addr == A_LO)   m_lo   <= cfg_wdata;
        if (cfg_addr == A_HI)   m_hi   <= cfg_wdata;
        if (cfg_addr == A_VAL)  m_val  <= cfg_wdata;
        if (cfg_addr == A_MSK)  m_msk  <= cfg_wdata;
      end
      exp_q <= model_hit();
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) check(brk_pulse === exp_q, {cur_req, " per-cycle model"},
                     {31'b0, brk_pulse}, {31'b0, exp_q});
  end

  task automatic wr(logic [31:0] a, logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [31:0] a, logic [31:0] exp, string req);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    check(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  task automatic acc(logic v, logic st, logic [31:0] a, logic [31:0] d, bit exp, string req);
    acc_valid = v; acc_store = st; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
    check(brk_pulse === exp, req, {31'b0, brk_pulse}, {31'b0, exp});
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    rd_chk(A_CTRL, 32'h0, "R1 control cleared by reset");
    acc(1'b1, 1'b0, 32'h1000, 32'h0, 1'b0, "R1 no breakpoint after reset");

    cur_req = "R11";
    wr(A_LO, 32'h0000_1000);
    wr(A_HI, 32'h0000_1FFF);
    wr(A_VAL, 32'hA5A5_0000);
    wr(A_MSK, 32'hFFFF_0000);
    rd_chk(A_LO, 32'h0000_1000, "R11 lower bound readback");
    rd_chk(A_HI, 32'h0000_1FFF, "R11 upper bound readback");
    rd_chk(A_VAL, 32'hA5A5_0000, "R11 value readback");
    rd_chk(A_MSK, 32'hFFFF_0000, "R11 mask readback");

    cur_req = "R2";
    wr(A_CTRL, 32'hFFFF_FFC0);
    rd_chk(A_CTRL, 32'h0, "R2 upper control bits read zero");
    wr(A_CTRL, 32'hFFFF_FF0C);
    rd_chk(A_CTRL, 32'h0000_000C, "R2 control field readback");

    cur_req = "R12";
    wr(BASE + 32'h0010_1024, 32'h3F);
    wr(BASE + 32'h0010_1031, 32'h7777_7777);
    wr(32'h0010_1020, 32'h3F);
    rd_chk(A_CTRL, 32'h0000_000C, "R12 control untouched by stray write");
    rd_chk(A_LO, 32'h0000_1000, "R12 lower bound untouched by stray write");
    rd_chk(BASE + 32'h0010_1024, 32'h0, "R12 unmapped read is zero");

    cur_req = "R3";
    acc(1'b1, 1'b0, 32'h1800, 32'hA5A5_0000, 1'b0, "R3 mode 0 load inside");
    acc(1'b1, 1'b1, 32'h1800, 32'hA5A5_0000, 1'b0, "R3 mode 0 store inside");

    cur_req = "R5";
    wr(A_CTRL, 32'h05);
    acc(1'b1, 1'b0, 32'h1000, 32'h0, 1'b1, "R5 lower bound inclusive");
    acc(1'b1, 1'b0, 32'h1FFF, 32'h0, 1'b1, "R5 upper bound inclusive");
    acc(1'b1, 1'b0, 32'h0FFF, 32'h0, 1'b0, "R5 below lower bound");
    acc(1'b1, 1'b0, 32'h2000, 32'h0, 1'b0, "R5 above upper bound");
    cur_req = "R4";
    acc(1'b1, 1'b1, 32'h1800, 32'h0, 1'b0, "R4 store ignored with loads only");
    wr(A_CTRL, 32'h09);
    acc(1'b1, 1'b1, 32'h1800, 32'h0, 1'b1, "R4 store checked with stores only");
    acc(1'b1, 1'b0, 32'h1800, 32'h0, 1'b0, "R4 load ignored with stores only");

    cur_req = "R6";
    wr(A_CTRL, 32'h1D);
    acc(1'b1, 1'b0, 32'h0FFF, 32'h0, 1'b1, "R6 just below range");
    acc(1'b1, 1'b1, 32'h2000, 32'h0, 1'b1, "R6 just above range");
    acc(1'b1, 1'b0, 32'h1000, 32'h0, 1'b0, "R6 lower bound is inside");
    acc(1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0, 1'b1, "R6 far address outside");

    cur_req = "R7";
    wr(A_CTRL, 32'h06);
    acc(1'b1, 1'b0, 32'h9000, 32'hA5A5_1234, 1'b1, "R7 masked equal, low bits ignored");
    acc(1'b1, 1'b0, 32'h9000, 32'hA5A4_0000, 1'b0, "R7 masked differ");

    cur_req = "R8";
    wr(A_CTRL, 32'h26);
    acc(1'b1, 1'b0, 32'h9000, 32'hA5A4_0000, 1'b1, "R8 differ matches");
    acc(1'b1, 1'b0, 32'h9000, 32'hA5A5_FFFF, 1'b0, "R8 equal does not match");

    cur_req = "R9";
    wr(A_CTRL, 32'h07);
    acc(1'b1, 1'b0, 32'h1234, 32'hA5A5_0001, 1'b1, "R9 both succeed");
    acc(1'b1, 1'b0, 32'h1234, 32'h0000_0001, 1'b0, "R9 address only");
    acc(1'b1, 1'b0, 32'h3000, 32'hA5A5_0001, 1'b0, "R9 value only");

    cur_req = "R10";
    acc(1'b0, 1'b0, 32'h1234, 32'hA5A5_0000, 1'b0, "R10 no valid no pulse");
    acc(1'b1, 1'b0, 32'h1234, 32'hA5A5_0000, 1'b1, "R10 first back-to-back");
    acc(1'b1, 1'b0, 32'h1235, 32'hA5A5_0000, 1'b1, "R10 second back-to-back");
    @(negedge clk);
    check(brk_pulse === 1'b0, "R10 pulse lasts one cycle", {31'b0, brk_pulse}, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule